// File: doc/BRIEF.md
# Converter Sequencing and Control Register

The block sits between a processor bus and an abstract analog-to-digital converter core. The core is reduced to three things: a start pulse, a one-cycle done strobe and a result word. Software uses one control/status word to pick an input channel, to choose between a single conversion and back-to-back conversions, and to enable an interrupt. The block turns each control write into start requests to the core. When a conversion finishes it stores the result in a data register. It then either raises a pending completion bit or drives the interrupt line.

One channel code is reserved. When all channel bits are set to one, the converter is shut down, and this is the state the block leaves reset in. When software moves away from that code, the core needs one throw-away conversion to settle. The block runs that conversion, discards its result, and then starts the real one without further software action. The result strobe has no back-pressure. The block accepts a done strobe in the cycle it arrives, and the core never waits.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset the control word reads 8'h1F (channel all ones, interrupt enable 0, continuous 0, status bit 0), the data register reads 0, `irq` is 0 and `conv_pwr_on` is 0.
- R2: Bus address 0 selects the control word and address 1 selects the data register. In the control word, bits 4:0 are the channel, bit 5 is continuous mode, bit 6 is interrupt enable and bit 7 is the read-only status bit. Written fields read back unchanged.
- R3: While the channel field is all ones, `conv_pwr_on` is 0 and no start is issued. A done strobe that arrives in this state leaves the data register unchanged.
- R4: A control write whose channel is not all ones makes `conv_start` high for exactly the next cycle, with `conv_chan` showing the written channel. A write during a conversion restarts it.
- R5: The first conversion after leaving the all-ones code is discarded. The data register and the pending bit keep their values, and a new start follows in the cycle after its done strobe.
- R6: In single mode, a done strobe loads the result into the data register and no further start is issued until the next control write.
- R7: In continuous mode, every done strobe loads the data register and is followed by a new start in the next cycle.
- R8: With interrupt enable 0, status bit 7 reads 1 while a stored result is pending and 0 otherwise. With interrupt enable 1, bit 7 reads 0.
- R9: With interrupt enable 1, `irq` rises in the cycle after a stored result. With interrupt enable 0, `irq` stays 0.
- R10: A read of the data register or any control write clears the pending bit and `irq`. A read of the control word clears neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (side effects only; data is combinational) |
| bus_addr | input | 1 | 0 = control word, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request, level |
| conv_start | output | 1 | One-cycle start request to the core |
| conv_chan | output | 5 | Channel shown to the core |
| conv_pwr_on | output | 1 | Core enable; low while the channel is all ones |
| conv_done | input | 1 | One-cycle completion strobe from the core |
| conv_result | input | 8 | Result word, valid with `conv_done` |

## Verification
The assertions assume a well-behaved core and bus. The core raises `conv_done` for one cycle only, and at least one cycle after a start. A fresh start abandons any conversion already in flight, so no stale strobe from it arrives later. Bus reads and writes are never issued in the same cycle. The bench's core model counts a fixed latency from each start and restarts that count whenever a new start arrives. Its bus tasks issue one strobe at a time and hold the address on the data register between accesses. The one exception is the shut-down test. There a done strobe from a conversion already in flight is deliberately delivered after the converter has been switched off.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_IDLE = 2'd1,
    SQ_WARM = 2'd2,
    SQ_RUN  = 2'd3
  } sq_state_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs #(
  parameter int DW   = 8,
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic            cfg_wr,
  output logic            wchan_off,
  output logic            ien,
  output logic            cont,
  output logic [CH_W-1:0] chan
);
  import adc_seq_pkg::*;

  localparam int CONT_BIT = CH_W;
  localparam int IEN_BIT  = CH_W + 1;
  localparam logic [CH_W-1:0] CH_OFF = '1;

  assign cfg_wr    = bus_wr && (bus_addr == ADDR_CTRL);
  assign wchan_off = (bus_wdata[CH_W-1:0] == CH_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien  <= 1'b0;
      cont <= 1'b0;
      chan <= CH_OFF;
    end else if (cfg_wr) begin
      ien  <= bus_wdata[IEN_BIT];
      cont <= bus_wdata[CONT_BIT];
      chan <= bus_wdata[CH_W-1:0];
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic wchan_off,
  input  logic cont,
  input  logic done,
  output logic start,
  output logic take,
  output logic warm,
  output logic pwr_on
);
  import adc_seq_pkg::*;

  sq_state_t state;
  logic      start_q;

  assign take   = done && (state == SQ_RUN) && !cfg_wr;
  assign warm   = (state == SQ_WARM);
  assign pwr_on = (state != SQ_OFF);
  assign start  = start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_OFF;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (cfg_wr) begin
        if (wchan_off) begin
          state <= SQ_OFF;
        end else begin
          start_q <= 1'b1;
          state   <= (state == SQ_OFF || state == SQ_WARM) ? SQ_WARM : SQ_RUN;
        end
      end else if (done) begin
        case (state)
          SQ_WARM: begin
            state   <= SQ_RUN;
            start_q <= 1'b1;
          end
          SQ_RUN: begin
            if (cont) start_q <= 1'b1;
            else      state   <= SQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  start_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> pwr_on);
  // R4
  wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wchan_off) |=> start_q);
  // R6
  single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cont) |=> !start_q);
  // R7
  cont_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cont) |=> start_q);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [RES_W-1:0] result,
  input  logic             clr,
  input  logic             ien,
  output logic [RES_W-1:0] data,
  output logic             pend,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      pend <= 1'b0;
    end else begin
      if (take) begin
        data <= result;
        pend <= 1'b1;
      end else if (clr) begin
        pend <= 1'b0;
      end
    end
  end

  assign irq = pend && ien;

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(take) || $rose(ien)));
  // R10
  clr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !take) |=> !pend);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int DW    = 8,
  parameter int CH_W  = 5,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic             conv_pwr_on,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);
  import adc_seq_pkg::*;

  localparam int CONT_BIT = CH_W;
  localparam int IEN_BIT  = CH_W + 1;
  localparam int STAT_BIT = CH_W + 2;

  logic            cfg_wr, wchan_off, ien, cont, take, warm, pend, clr;
  logic [CH_W-1:0] chan;
  logic [RES_W-1:0] data_q;
  logic [DW-1:0]   ctrl_word, data_word;

  adc_ctl_regs #(.DW(DW), .CH_W(CH_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cfg_wr(cfg_wr), .wchan_off(wchan_off),
    .ien(ien), .cont(cont), .chan(chan)
  );

  adc_conv_seq seq_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wchan_off(wchan_off),
    .cont(cont), .done(conv_done), .start(conv_start), .take(take),
    .warm(warm), .pwr_on(conv_pwr_on)
  );

  assign clr = cfg_wr || (bus_rd && (bus_addr == ADDR_DATA));

  adc_result_hold #(.RES_W(RES_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .take(take), .result(conv_result),
    .clr(clr), .ien(ien), .data(data_q), .pend(pend), .irq(irq)
  );

  assign conv_chan = chan;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CH_W-1:0] = chan;
    ctrl_word[CONT_BIT] = cont;
    ctrl_word[IEN_BIT]  = ien;
    ctrl_word[STAT_BIT] = pend && !ien;
    data_word = '0;
    data_word[RES_W-1:0] = data_q;
  end

  assign bus_rdata = (bus_addr == ADDR_CTRL) ? ctrl_word : data_word;

  // R5
  warm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && conv_done && !cfg_wr) |=> $stable(data_q));
  // R3
  off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_pwr_on && !cfg_wr) |=> $stable(data_q));
  // R9
  irq_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !cfg_wr) |=> !irq);
endmodule

// File: tb/adc_conv_ctrl_tb.sv
`timescale 1ns/1ps
module adc_conv_ctrl_tb_top;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b1;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, conv_start, conv_pwr_on;
  logic [4:0] conv_chan;
  logic       conv_done = 1'b0;
  logic [7:0] conv_result = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_pwr_on(conv_pwr_on), .conv_done(conv_done), .conv_result(conv_result)
  );

  // expected-state trackers
  bit off_exp = 1, warm_exp = 0, ien_exp = 0, cont_exp = 0;
  logic [7:0] last_data = 8'h00;
  logic [8:0] sb_q[$];  // {keep, value}
  bit         chk_due = 0;
  int         cnt = 0;
  logic [7:0] next_val = 8'h21;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // core model: pushes expected items into the scoreboard queue
  always @(negedge clk) begin
    if (conv_done) chk_due = 1;
    conv_done = 1'b0;
    if (conv_start) cnt = LAT;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done   = 1'b1;
        conv_result = next_val;
        if (off_exp)       sb_q.push_back({1'b0, next_val});
        else if (warm_exp) begin sb_q.push_back({1'b0, next_val}); warm_exp = 0; end
        else               sb_q.push_back({1'b1, next_val});
        next_val = next_val + 8'd37;
      end
    end
  end

  // monitor: pops and compares once the design has absorbed the strobe
  always @(negedge clk) begin
    #2;
    if (chk_due) begin
      logic [8:0] it;
      chk_due = 0;
      it = sb_q.pop_front();
      if (it[8]) begin
        if (bus_addr == 1'b1) check("R6/R7 data", bus_rdata, it[7:0]);
        check("R9 irq", irq, ien_exp);
        last_data = it[7:0];
      end else if (bus_addr == 1'b1) begin
        check("R5/R3 data kept", bus_rdata, last_data);
      end
      check("R5/R6/R7 restart", conv_start, (!off_exp) && (!it[8] || cont_exp));
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    bus_addr = 1'b0; bus_wdata = v; bus_wr = 1'b1;
    if (v[4:0] == 5'h1F) off_exp = 1;
    else begin
      if (off_exp) warm_exp = 1;
      off_exp = 0;
    end
    ien_exp = v[6]; cont_exp = v[5];
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, d); check("R1 ctrl", d, 8'h1F);
    rd(1'b1, d); check("R1 data", d, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 pwr", conv_pwr_on, 1'b0);
    check("R3 no start off", conv_start, 1'b0);

    // single mode from power-down: warm-up then one stored result
    wr_ctrl(8'h03);
    check("R4 start", conv_start, 1'b1);
    check("R4 chan", conv_chan, 5'd3);
    idle(1);
    check("R4 one cycle", conv_start, 1'b0);
    idle(16);
    check("R6 queue empty", sb_q.size(), 0);
    rd(1'b0, d); check("R8 status pend", d, 8'h83);
    rd(1'b0, d); check("R10 ctrl read keeps", d, 8'h83);
    rd(1'b1, d); check("R2 data read", d, last_data);
    rd(1'b0, d); check("R10 data read clears", d, 8'h03);

    // interrupt mode, no warm-up
    wr_ctrl(8'h44);
    check("R4 start ien", conv_start, 1'b1);
    idle(10);
    check("R9 irq", irq, 1'b1);
    rd(1'b0, d); check("R8 status ien", d, 8'h44);
    check("R10 ctrl read keeps irq", irq, 1'b1);
    wr_ctrl(8'h44);
    check("R10 write clears irq", irq, 1'b0);
    idle(10);
    check("R9 irq again", irq, 1'b1);
    rd(1'b1, d);
    check("R10 data read clears irq", irq, 1'b0);

    // continuous mode and restart mid-conversion
    wr_ctrl(8'h65);
    check("R4 chan5", conv_chan, 5'd5);
    idle(2);
    wr_ctrl(8'h65);   // R4 restart while converting
    idle(30);
    // shut down with a conversion in flight
    idle(2);
    wr_ctrl(8'h7F);
    check("R3 pwr off", conv_pwr_on, 1'b0);
    check("R3 no start", conv_start, 1'b0);
    check("R10 irq cleared", irq, 1'b0);
    idle(10);
    rd(1'b0, d); check("R2 ctrl off", d, 8'h7F);

    // continuous without interrupt after power-down: warm-up again
    wr_ctrl(8'h22);
    idle(25);
    check("R9 no irq", irq, 1'b0);
    wr_ctrl(8'h1F);
    idle(10);
    check("R5 queue drained", sb_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule